// File: doc/BRIEF.md
# UTOPIA Slave Cell Receive Port

This block is the receive half of a 16-bit UTOPIA Level 2 style slave that answers to one address on a shared multi-PHY bus. An ATM layer master polls the 5-bit address bus. When the address equals the programmed PHY identifier, the block drives its cell-available line and reports whether a whole cell fits in its buffer. Under the same address match, each word that the master marks with the enable is captured together with its start-of-cell flag and odd parity bit.

A cell is 27 words, with start-of-cell on word 0. Each cell is gathered into a single-cell buffer and its parity result is accumulated word by word. A cell that contains a parity error is dropped when checking is active, and the drop is reported with a one-cycle pulse. Any other complete cell is played out as 27 consecutive words on a valid/start/end stream. A diagnostic field can route the local transmitter's bus into the receive path. In that loop-back mode the transmitter acts as master and this port as slave, and the external receive pins are ignored.

Top module: `utopia_rx_slave`

## Requirements
- R1: After reset `cell_valid_o` and `cell_drop_o` are 0, and `rx_clav_o` is 1 while the selected address equals `cfg_phy_id_i`.
- R2: A word is in parity error exactly when the XOR of its 16 data bits and its parity bit is 0. A word whose XOR is 1 is error-free.
- R3: With `cfg_par_ign_i`=0, a cell in which any word has a parity error produces no output words. Instead `cell_drop_o` is 1 for exactly one cycle, starting one clock after the last word is captured.
- R4: With `cfg_par_ign_i`=1, a cell is delivered whatever its parity.
- R5: When the selected address differs from `cfg_phy_id_i`, `rx_clav_oe_o` and `rx_clav_o` are 0 and every word on the bus is ignored.
- R6: `rx_clav_o` is 0 for as long as the buffer holds a cell that is being played out, and it returns to 1 when the playout ends.
- R7: Data and start-of-cell are captured only in cycles where the selected enable is 1. Enable-low cycles in the middle of a cell do not disturb it.
- R8: A cell is 27 words with start-of-cell on word 0. An accepted cell is output from one clock after its last word is captured, on 27 consecutive cycles in arrival order. `cell_sop_o` marks the first output word and `cell_eop_o` marks the last.
- R9: A start-of-cell that arrives in the middle of a cell aborts the partial cell, including any parity error already seen in it, and starts a new cell at word 0.
- R10: `cfg_diag_i`=01 selects the loop-back bus (`lb_*`) and ignores the external receive inputs. The values 00, 10 and 11 select the external inputs and ignore the loop-back bus.
- R11: Words without a preceding start-of-cell are ignored. Words that arrive while a cell is being played out are also ignored, even when they carry start-of-cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive clock; all inputs sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_phy_id_i | input | 5 | PHY identifier this port answers to |
| cfg_par_ign_i | input | 1 | 0: drop cells with parity errors; 1: ignore parity |
| cfg_diag_i | input | 2 | 01 loop-back, otherwise normal |
| rx_enb_i | input | 1 | External receive enable from master |
| rx_soc_i | input | 1 | External start-of-cell |
| rx_data_i | input | 16 | External receive data |
| rx_prty_i | input | 1 | External odd parity over data |
| rx_addr_i | input | 5 | External polling/selection address |
| lb_enb_i | input | 1 | Loop-back enable from local transmitter |
| lb_soc_i | input | 1 | Loop-back start-of-cell |
| lb_data_i | input | 16 | Loop-back data |
| lb_prty_i | input | 1 | Loop-back parity |
| lb_addr_i | input | 5 | Loop-back address |
| rx_clav_o | output | 1 | Cell-available, valid when output enable is 1 |
| rx_clav_oe_o | output | 1 | Output enable of cell-available (address match) |
| cell_valid_o | output | 1 | Output word valid |
| cell_sop_o | output | 1 | First word of output cell |
| cell_eop_o | output | 1 | Last word of output cell |
| cell_data_o | output | 16 | Output word |
| cell_drop_o | output | 1 | One-cycle pulse when a cell is discarded |

## Verification
The discard decision and cell completion coincide when the final word of a cell carries the only parity error. The bench provokes this with checking active and expects a drop pulse and no words. It then repeats the cell with checking off and expects the full cell. A restart can also coincide with a pending error. The bench corrupts word 3 of a partial cell and then sends a fresh start-of-cell mid-cell. The following clean cell must be delivered intact with no drop pulse, which shows that the error flag was cleared in the same cycle the count restarted.

// File: rtl/utopia_rx_pkg.sv
package utopia_rx_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 5;
  localparam int DIAG_W = 2;
  localparam logic [DIAG_W-1:0] DIAG_LOOP = 2'b01;

  typedef struct packed {
    logic              enb;
    logic              soc;
    logic [DATA_W-1:0] data;
    logic              prty;
    logic [ADDR_W-1:0] addr;
  } rx_bus_t;
endpackage

// File: rtl/utopia_rx_port_mux.sv
module utopia_rx_port_mux
  import utopia_rx_pkg::*;
(
  input  logic [DIAG_W-1:0] diag_i,
  input  rx_bus_t           ext_i,
  input  rx_bus_t           lb_i,
  output rx_bus_t           bus_o
);
  // reserved codes fall back to normal
  assign bus_o = (diag_i == DIAG_LOOP) ? lb_i : ext_i;
endmodule

// File: rtl/utopia_rx_parity.sv
module utopia_rx_parity #(
  parameter int W = 16
) (
  input  logic [W-1:0] data_i,
  input  logic         prty_i,
  output logic         err_o
);
  // odd parity: total ones must be odd
  assign err_o = ~(^{data_i, prty_i});
endmodule

// File: rtl/utopia_rx_cell_buf.sv
module utopia_rx_cell_buf #(
  parameter int DATA_W     = 16,
  parameter int CELL_WORDS = 27
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              soc_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              perr_i,
  input  logic              par_ign_i,
  output logic              free_o,
  output logic              valid_o,
  output logic              sop_o,
  output logic              eop_o,
  output logic [DATA_W-1:0] data_o,
  output logic              drop_o
);
  localparam int CNT_W = $clog2(CELL_WORDS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CELL_WORDS - 1);

  logic [DATA_W-1:0] mem [CELL_WORDS];
  logic              draining, active, err_q;
  logic [CNT_W-1:0]  wr_cnt, rd_cnt, wr_idx;
  logic              take, err_nxt;

  assign take    = wr_en_i & ~draining & (soc_i | active);
  assign wr_idx  = soc_i ? '0 : wr_cnt;
  assign err_nxt = (~soc_i & err_q) | perr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      draining <= 1'b0;
      active   <= 1'b0;
      err_q    <= 1'b0;
      wr_cnt   <= '0;
      rd_cnt   <= '0;
      drop_o   <= 1'b0;
    end else begin
      drop_o <= 1'b0;
      if (draining) begin
        if (rd_cnt == LAST) begin
          draining <= 1'b0;
          rd_cnt   <= '0;
        end else begin
          rd_cnt <= rd_cnt + 1'b1;
        end
      end else if (take) begin
        if (wr_idx == LAST) begin
          active <= 1'b0;
          wr_cnt <= '0;
          err_q  <= 1'b0;
          if (err_nxt && !par_ign_i) drop_o   <= 1'b1;
          else                       draining <= 1'b1;
        end else begin
          active <= 1'b1;
          wr_cnt <= wr_idx + 1'b1;
          err_q  <= err_nxt;
        end
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (take) mem[wr_idx] <= data_i;
  end

  assign free_o  = ~draining;
  assign valid_o = draining;
  assign sop_o   = draining & (rd_cnt == '0);
  assign eop_o   = draining & (rd_cnt == LAST);
  assign data_o  = mem[rd_cnt];
endmodule

// File: rtl/utopia_rx_slave.sv
module utopia_rx_slave
  import utopia_rx_pkg::*;
#(
  parameter int CELL_WORDS = 27
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] cfg_phy_id_i,
  input  logic              cfg_par_ign_i,
  input  logic [DIAG_W-1:0] cfg_diag_i,
  input  logic              rx_enb_i,
  input  logic              rx_soc_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_prty_i,
  input  logic [ADDR_W-1:0] rx_addr_i,
  input  logic              lb_enb_i,
  input  logic              lb_soc_i,
  input  logic [DATA_W-1:0] lb_data_i,
  input  logic              lb_prty_i,
  input  logic [ADDR_W-1:0] lb_addr_i,
  output logic              rx_clav_o,
  output logic              rx_clav_oe_o,
  output logic              cell_valid_o,
  output logic              cell_sop_o,
  output logic              cell_eop_o,
  output logic [DATA_W-1:0] cell_data_o,
  output logic              cell_drop_o
);
  rx_bus_t ext_bus, lb_bus, bus;
  logic    match, perr, free;

  assign ext_bus = '{enb: rx_enb_i, soc: rx_soc_i, data: rx_data_i,
                     prty: rx_prty_i, addr: rx_addr_i};
  assign lb_bus  = '{enb: lb_enb_i, soc: lb_soc_i, data: lb_data_i,
                     prty: lb_prty_i, addr: lb_addr_i};

  utopia_rx_port_mux u_mux (
    .diag_i (cfg_diag_i),
    .ext_i  (ext_bus),
    .lb_i   (lb_bus),
    .bus_o  (bus)
  );

  utopia_rx_parity #(.W(DATA_W)) u_par (
    .data_i (bus.data),
    .prty_i (bus.prty),
    .err_o  (perr)
  );

  assign match = (bus.addr == cfg_phy_id_i);

  utopia_rx_cell_buf #(.DATA_W(DATA_W), .CELL_WORDS(CELL_WORDS)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (match & bus.enb),
    .soc_i     (bus.soc),
    .data_i    (bus.data),
    .perr_i    (perr),
    .par_ign_i (cfg_par_ign_i),
    .free_o    (free),
    .valid_o   (cell_valid_o),
    .sop_o     (cell_sop_o),
    .eop_o     (cell_eop_o),
    .data_o    (cell_data_o),
    .drop_o    (cell_drop_o)
  );

  // line released when another PHY is addressed
  assign rx_clav_oe_o = match;
  assign rx_clav_o    = match & free;
endmodule

// File: rtl/utopia_rx_slave_chk.sv
module utopia_rx_slave_chk #(
  parameter int CELL_WORDS = 27
) (
  input logic clk_i,
  input logic rst_ni,
  input logic rx_clav_o,
  input logic rx_clav_oe_o,
  input logic cell_valid_o,
  input logic cell_sop_o,
  input logic cell_eop_o,
  input logic cell_drop_o
);
  localparam int RW = $clog2(CELL_WORDS + 1);
  logic [RW-1:0] run_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        run_cnt <= '0;
    else if (!cell_valid_o || cell_eop_o) run_cnt <= '0;
    else                                run_cnt <= run_cnt + 1'b1;
  end

  assert_clav_needs_oe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_clav_o |-> rx_clav_oe_o);
  assert_busy_no_clav_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cell_valid_o |-> !rx_clav_o);
  assert_drop_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cell_drop_o |=> !cell_drop_o);
  assert_drop_no_words_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cell_drop_o |-> !cell_valid_o);
  assert_sop_leads_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cell_valid_o) |-> cell_sop_o);
  assert_eop_ends_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cell_valid_o && cell_eop_o) |=> !cell_valid_o);
  assert_cell_len_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cell_valid_o && cell_eop_o) |-> (run_cnt == RW'(CELL_WORDS - 1)));
endmodule

bind utopia_rx_slave utopia_rx_slave_chk #(.CELL_WORDS(CELL_WORDS)) u_chk (.*);

// File: tb/utopia_rx_slave_test.sv
module utopia_rx_slave_test;
  localparam int NW = 27;
  localparam logic [4:0] PHY = 5'd9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  cfg_phy_id = PHY;
  logic        cfg_par_ign = 1'b0;
  logic [1:0]  cfg_diag = 2'b00;
  logic        rx_enb = 0, rx_soc = 0, rx_prty = 0;
  logic [15:0] rx_data = '0;
  logic [4:0]  rx_addr = PHY;
  logic        lb_enb = 0, lb_soc = 0, lb_prty = 0;
  logic [15:0] lb_data = '0;
  logic [4:0]  lb_addr = PHY;
  logic        clav, clav_oe, valid, sop, eop, drop;
  logic [15:0] dout;

  int n_chk = 0, n_bad = 0;
  bit ext_junk = 0;
  logic [4:0] cur_addr = PHY;

  always #5 clk = ~clk;

  utopia_rx_slave uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_phy_id_i(cfg_phy_id),
    .cfg_par_ign_i(cfg_par_ign), .cfg_diag_i(cfg_diag),
    .rx_enb_i(rx_enb), .rx_soc_i(rx_soc), .rx_data_i(rx_data),
    .rx_prty_i(rx_prty), .rx_addr_i(rx_addr),
    .lb_enb_i(lb_enb), .lb_soc_i(lb_soc), .lb_data_i(lb_data),
    .lb_prty_i(lb_prty), .lb_addr_i(lb_addr),
    .rx_clav_o(clav), .rx_clav_oe_o(clav_oe), .cell_valid_o(valid),
    .cell_sop_o(sop), .cell_eop_o(eop), .cell_data_o(dout),
    .cell_drop_o(drop)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // R2: good word has odd total ones
  task automatic put(bit lb, bit en, bit soc, logic [15:0] d, bit bad);
    if (lb) begin
      lb_enb = en; lb_soc = soc; lb_data = d; lb_addr = cur_addr;
      lb_prty = bad ? ^d : ~^d;
    end else begin
      rx_enb = en; rx_soc = soc; rx_data = d; rx_addr = cur_addr;
      rx_prty = bad ? ^d : ~^d;
    end
  endtask

  task automatic quiet();
    lb_enb = 0; lb_soc = 0; lb_addr = cur_addr;
    if (ext_junk) begin
      rx_enb = 1; rx_soc = 1; rx_data = 16'hdead; rx_addr = PHY; rx_prty = 1'b0;
    end else begin
      rx_enb = 0; rx_soc = 0; rx_addr = cur_addr;
    end
  endtask

  task automatic send_cell(bit lb, logic [15:0] base, int bad_idx, bit gaps);
    for (int i = 0; i < NW; i++) begin
      if (gaps && (i % 3 == 1)) begin
        @(negedge clk);
        put(lb, 0, 1, 16'h5a5a, 1); // enb low: soc and data must be ignored
      end
      @(negedge clk);
      put(lb, 1, i == 0, base + 16'(i), i == bad_idx);
    end
  endtask

  task automatic expect_cell(string req, logic [15:0] base, bit junk);
    for (int i = 0; i < NW; i++) begin
      @(negedge clk);
      quiet();
      if (junk) put(cfg_diag == 2'b01, 1, 1, 16'hbeef, 0);
      #1;
      check(req, "valid", valid, 1);
      check(req, "sop", sop, i == 0);
      check(req, "eop", eop, i == NW - 1);
      check(req, "data", dout, base + 16'(i));
      check(req, "drop", drop, 0);
      if (i == 0) check("R6", "clav busy", clav, 0);
    end
    @(negedge clk);
    quiet();
    #1;
    check(req, "valid after eop", valid, 0);
    check("R6", "clav free again", clav, cur_addr == PHY);
  endtask

  task automatic expect_none(string req, bit drop_exp);
    @(negedge clk);
    quiet();
    #1;
    check(req, "drop pulse", drop, drop_exp);
    check(req, "no words", valid, 0);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      #1;
      check(req, "quiet valid", valid, 0);
      check(req, "quiet drop", drop, 0);
    end
  endtask

  task automatic t_reset();
    #1;
    check("R1", "valid", valid, 0);
    check("R1", "drop", drop, 0);
    check("R1", "clav", clav, 1);
    check("R1", "clav_oe", clav_oe, 1);
  endtask

  task automatic t_good_cell();
    send_cell(0, 16'h0000, -1, 0);
    expect_cell("R8", 16'h0000, 0);
  endtask

  task automatic t_parity_drop();
    cfg_par_ign = 0;
    send_cell(0, 16'h1100, NW - 1, 0);  // error only on last word
    expect_none("R3", 1);
    send_cell(0, 16'h1200, 5, 0);
    expect_none("R2", 1);
  endtask

  task automatic t_parity_ignore();
    cfg_par_ign = 1;
    send_cell(0, 16'h2200, NW - 1, 0);
    expect_cell("R4", 16'h2200, 0);
    cfg_par_ign = 0;
  endtask

  task automatic t_addr_miss();
    @(negedge clk);
    cur_addr = PHY ^ 5'd1;
    quiet();
    #1;
    check("R5", "clav_oe", clav_oe, 0);
    check("R5", "clav", clav, 0);
    send_cell(0, 16'h3300, -1, 0);
    expect_none("R5", 0);
    cur_addr = PHY;
  endtask

  task automatic t_enb_gaps();
    send_cell(0, 16'h4400, -1, 1);
    expect_cell("R7", 16'h4400, 0);
  endtask

  task automatic t_restart();
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      put(0, 1, i == 0, 16'h7700 + 16'(i), i == 3);
    end
    send_cell(0, 16'h5500, -1, 0);
    expect_cell("R9", 16'h5500, 0);
  endtask

  task automatic t_no_soc_and_busy();
    for (int i = 0; i < NW; i++) begin
      @(negedge clk);
      put(0, 1, 0, 16'h6600 + 16'(i), 0);
    end
    expect_none("R11", 0);
    send_cell(0, 16'h6800, -1, 0);
    expect_cell("R11", 16'h6800, 1);  // soc words during playout
    expect_none("R11", 0);
  endtask

  task automatic t_loopback();
    @(negedge clk);
    ext_junk = 1;
    cfg_diag = 2'b01;
    quiet();
    send_cell(1, 16'h8800, -1, 0);
    expect_cell("R10", 16'h8800, 0);
    @(negedge clk);
    ext_junk = 0;
    cfg_diag = 2'b10;  // reserved -> normal
    quiet();
    send_cell(1, 16'h9900, -1, 0);
    expect_none("R10", 0);
    send_cell(0, 16'h9a00, -1, 0);
    expect_cell("R10", 16'h9a00, 0);
    cfg_diag = 2'b00;
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_good_cell();
    t_parity_drop();
    t_parity_ignore();
    t_addr_miss();
    t_enb_gaps();
    t_restart();
    t_no_soc_and_busy();
    t_loopback();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule